// File: doc/BRIEF.md
# Dual-Core Mailbox Queue Pair

This block lets two processor cores that share one clock pass 32-bit words to each other. It holds two independent one-way queues of eight words each. One carries words from core 0 to core 1, the other from core 1 to core 0. Each core sees only the write end of its outgoing queue and the read end of its incoming queue. Each core also has a status word and one interrupt line.

The outgoing side of each core is a valid/ready stream, `tx_valid`, `tx_data` and `tx_ready`. A word is taken on a clock edge when `tx_valid` is high and there is room. There is room when `tx_ready` is high, or when the same queue is popped in that cycle. The back-pressure rule is stricter than a plain stream. A producer must not raise `tx_valid` while `tx_ready` is low, because the block does not hold such a word for later. It drops the word and records the misuse in a sticky flag.

The incoming side works the same way in reverse. `rx_valid` shows that a word is at the head of the queue, and `rx_data` carries that word without a clock of delay. A pulse on `rx_pop` consumes the word on the next edge. A pop while `rx_valid` is low returns zero and is recorded in a second sticky flag. The status word can be read at any time. A status write can clear the sticky flags, and the interrupt line asks the core for attention.

Top module: `mbox_pair`

## Requirements
- R1: Each direction has its own queue of 8 words of 32 bits. The queue accepts 8 words when empty and delivers them in the order they were written.
- R2: A word written on core 0's transmit port comes out on core 1's receive port, and a word written on core 1's transmit port comes out on core 0's receive port.
- R3: Status bit 1 (ready) and `tx_ready` are 1 exactly when the core's outgoing queue holds fewer than 8 words.
- R4: Status bit 0 (valid) and `rx_valid` are 1 exactly when the core's incoming queue holds at least one word.
- R5: A push to a full outgoing queue that is not popped in the same cycle leaves the queue unchanged. It sets status bit 2 (overflow) of the writing core.
- R6: A pop from an empty incoming queue leaves the queue unchanged and presents zero on `rx_data`. It sets status bit 3 (underflow) of the reading core.
- R7: A status write clears each sticky flag whose data bit is 1 and leaves the flag unchanged where the bit is 0. The write has no effect on bits 0 and 1. Bits 31 to 4 always read as zero.
- R8: A sticky flag that is cleared and set again in the same cycle ends up set.
- R9: Each core's `irq` is high exactly when its valid, overflow or underflow bit is 1.
- R10: A push and a pop on the same queue in the same cycle are both accepted when the pop is legal, including when the queue is full. No overflow is recorded.
- R11: Reset empties both queues and clears all four sticky flags, leaving each status word at 0x2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock of both cores |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 2 | Per core: push request into its outgoing queue |
| tx_data | input | 2x32 | Per core: word to push |
| tx_ready | output | 2 | Per core: outgoing queue has room |
| rx_pop | input | 2 | Per core: consume the head of its incoming queue |
| rx_valid | output | 2 | Per core: incoming queue holds a word |
| rx_data | output | 2x32 | Per core: head word of the incoming queue, zero when empty |
| st_we | input | 2 | Per core: status write strobe |
| st_wdata | input | 2x32 | Per core: status write data, bits 2 and 3 clear flags |
| st_rdata | output | 2x32 | Per core: status word |
| irq | output | 2 | Per core: interrupt request |

## Verification
The assertions assume nothing about the inputs. The pops and pushes that break the stream rules are legal stimulus here, and their outcome is exactly what the flag properties check. They do assume that the reset is held for at least one edge, so that the count and pointers start at zero before any history is compared. The stimulus drives every input just after a falling edge. It holds each input for one full cycle, so every request is seen on exactly one rising edge. Some steps combine a push, a pop and a status write in one cycle, to reach the full-queue, empty-queue and clear-versus-set corners.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  localparam int NCORE  = 2;
  localparam int ST_VLD = 0;
  localparam int ST_RDY = 1;
  localparam int ST_OVF = 2;
  localparam int ST_UDF = 3;
  localparam int ST_USED = 4;
endpackage

// File: rtl/mbox_queue.sv
`timescale 1ns/1ps
module mbox_queue #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         full,
  output logic         empty,
  output logic         push_drop,
  output logic         pop_drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign empty     = (cnt == '0);
  assign full      = (cnt == CW'(DEPTH));
  assign pop_ok    = pop & ~empty;
  assign push_ok   = push & (~full | pop_ok);
  assign push_drop = push & ~push_ok;
  assign pop_drop  = pop & empty;
  assign pop_data  = empty ? '0 : mem[rd_ptr];

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= step_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= step_ptr(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R1
  AST_FULL_PUSH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> (cnt == $past(cnt) && wr_ptr == $past(wr_ptr))); // R5
  AST_EMPTY_POP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    pop_drop |=> rd_ptr == $past(rd_ptr)); // R6
  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pop_drop |-> pop_data == '0); // R6
  AST_FULL_BOTH_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop) |=> full); // R10
endmodule

// File: rtl/mbox_status.sv
`timescale 1ns/1ps
module mbox_status
  import mbox_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_nonempty,
  input  logic              tx_notfull,
  input  logic              push_drop,
  input  logic              pop_drop,
  input  logic              st_we,
  input  logic [STAT_W-1:0] st_wdata,
  output logic [STAT_W-1:0] st_rdata,
  output logic              irq
);
  logic ovf, udf;
  logic clr_ovf, clr_udf;

  assign clr_ovf = st_we & st_wdata[ST_OVF];
  assign clr_udf = st_we & st_wdata[ST_UDF];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      udf <= 1'b0;
    end else begin
      ovf <= (ovf & ~clr_ovf) | push_drop;
      udf <= (udf & ~clr_udf) | pop_drop;
    end
  end

  always_comb begin
    st_rdata         = '0;
    st_rdata[ST_VLD] = rx_nonempty;
    st_rdata[ST_RDY] = tx_notfull;
    st_rdata[ST_OVF] = ovf;
    st_rdata[ST_UDF] = udf;
  end

  assign irq = rx_nonempty | ovf | udf;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr_ovf) |=> ovf); // R7
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (udf && !clr_udf) |=> udf); // R7
  AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> st_rdata[ST_OVF]); // R8
  AST_UDF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pop_drop |=> st_rdata[ST_UDF]); // R8
  AST_IRQ_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop || pop_drop) |=> irq); // R9
endmodule

// File: rtl/mbox_pair.sv
`timescale 1ns/1ps
module mbox_pair
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int STAT_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NCORE-1:0]             tx_valid,
  input  logic [NCORE-1:0][DATA_W-1:0] tx_data,
  output logic [NCORE-1:0]             tx_ready,
  input  logic [NCORE-1:0]             rx_pop,
  output logic [NCORE-1:0]             rx_valid,
  output logic [NCORE-1:0][DATA_W-1:0] rx_data,
  input  logic [NCORE-1:0]             st_we,
  input  logic [NCORE-1:0][STAT_W-1:0] st_wdata,
  output logic [NCORE-1:0][STAT_W-1:0] st_rdata,
  output logic [NCORE-1:0]             irq
);
  // queue d carries words written by core d to the other core
  logic [NCORE-1:0]             q_full, q_empty, q_pdrop, q_rdrop, q_pop;
  logic [NCORE-1:0][DATA_W-1:0] q_head;

  for (genvar d = 0; d < NCORE; d++) begin : g_q
    localparam int PEER = NCORE - 1 - d;
    assign q_pop[d] = rx_pop[PEER];
    mbox_queue #(.W(DATA_W), .DEPTH(DEPTH)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (tx_valid[d]),
      .push_data (tx_data[d]),
      .pop       (q_pop[d]),
      .pop_data  (q_head[d]),
      .full      (q_full[d]),
      .empty     (q_empty[d]),
      .push_drop (q_pdrop[d]),
      .pop_drop  (q_rdrop[d])
    );
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    localparam int PEER = NCORE - 1 - c;
    assign tx_ready[c] = ~q_full[c];
    assign rx_valid[c] = ~q_empty[PEER];
    assign rx_data[c]  = q_head[PEER];
    mbox_status #(.STAT_W(STAT_W)) u_st (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_nonempty (~q_empty[PEER]),
      .tx_notfull  (~q_full[c]),
      .push_drop   (q_pdrop[c]),
      .pop_drop    (q_rdrop[PEER]),
      .st_we       (st_we[c]),
      .st_wdata    (st_wdata[c]),
      .st_rdata    (st_rdata[c]),
      .irq         (irq[c])
    );
  end
endmodule

// File: tb/mbox_pair_test.sv
`timescale 1ns/1ps
module mbox_pair_test;
  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       tx_valid, tx_ready, rx_pop, rx_valid, st_we, irq;
  logic [1:0][31:0] tx_data, rx_data, st_wdata, st_rdata;

  int total = 0;
  int bad   = 0;
  logic [31:0] q0[$];  // model of words from core 0
  logic [31:0] q1[$];  // model of words from core 1
  logic [1:0]  mov, mud;

  always #10 clk = ~clk;

  mbox_pair uut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_pop(rx_pop), .rx_valid(rx_valid), .rx_data(rx_data),
    .st_we(st_we), .st_wdata(st_wdata), .st_rdata(st_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic int qsize(input int d);
    return (d == 0) ? q0.size() : q1.size();
  endfunction

  task automatic check_all(input string tag);
    for (int c = 0; c < 2; c++) begin
      logic [31:0] e;
      e = '0;
      e[0] = qsize(1 - c) != 0;
      e[1] = qsize(c) < 8;
      e[2] = mov[c];
      e[3] = mud[c];
      chk(tag, "status word R7", st_rdata[c], e);
      chk(tag, "irq R9", {31'b0, irq[c]}, {31'b0, e[0] | e[2] | e[3]});
      chk(tag, "tx_ready R3", {31'b0, tx_ready[c]}, {31'b0, e[1]});
      chk(tag, "rx_valid R4", {31'b0, rx_valid[c]}, {31'b0, e[0]});
    end
  endtask

  // Driver and scoreboard: the model is updated from the driven requests,
  // the head word is compared before the edge, status after it.
  task automatic step(input string tag);
    logic [1:0] sov, sud;
    sov = '0; sud = '0;
    #1;
    for (int c = 0; c < 2; c++) begin
      if (rx_pop[c]) begin
        if (qsize(1 - c) == 0) begin
          chk(tag, "underflow data R6", rx_data[c], 32'h0);
          sud[c] = 1'b1;
        end else if (c == 1) begin
          chk(tag, "pop data R2", rx_data[c], q0[0]);
          void'(q0.pop_front());
        end else begin
          chk(tag, "pop data R1", rx_data[c], q1[0]);
          void'(q1.pop_front());
        end
      end
    end
    for (int c = 0; c < 2; c++) begin
      if (tx_valid[c]) begin
        if (qsize(c) < 8) begin
          if (c == 0) q0.push_back(tx_data[c]);
          else        q1.push_back(tx_data[c]);
        end else sov[c] = 1'b1;
      end
      if (st_we[c]) begin
        if (st_wdata[c][2]) mov[c] = 1'b0;
        if (st_wdata[c][3]) mud[c] = 1'b0;
      end
    end
    mov = mov | sov;
    mud = mud | sud;
    @(posedge clk);
    @(negedge clk);
    tx_valid = '0; rx_pop = '0; st_we = '0; tx_data = '0; st_wdata = '0;
    check_all(tag);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tx_valid = '0; rx_pop = '0; st_we = '0; tx_data = '0; st_wdata = '0;
    mov = '0; mud = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R11");

    // core 0 to core 1 path, order kept
    for (int i = 0; i < 3; i++) begin
      tx_valid[0] = 1'b1; tx_data[0] = 32'hA5A5_0000 + i; step("R2");
    end
    for (int i = 0; i < 3; i++) begin
      rx_pop[1] = 1'b1; step("R2");
    end

    // fill core 1 to core 0, then overflow
    for (int i = 0; i < 8; i++) begin
      tx_valid[1] = 1'b1; tx_data[1] = 32'h0B00_0000 + i * 7; step("R3");
    end
    tx_valid[1] = 1'b1; tx_data[1] = 32'hDEAD_BEEF; step("R5");

    // writes of 0 keep flags, ready/valid unaffected
    st_we[1] = 1'b1; st_wdata[1] = 32'hFFFF_FFFB; step("R7");
    st_we[0] = 1'b1; st_wdata[0] = 32'hFFFF_FFFF; step("R7");
    st_we[1] = 1'b1; st_wdata[1] = 32'h0000_0004; step("R7");

    // full queue, push and pop together
    tx_valid[1] = 1'b1; tx_data[1] = 32'hC0FF_EE01; rx_pop[0] = 1'b1; step("R10");
    for (int i = 0; i < 8; i++) begin
      rx_pop[0] = 1'b1; step("R1");
    end

    // underflow, then clear and new underflow together
    rx_pop[0] = 1'b1; step("R6");
    rx_pop[0] = 1'b1; st_we[0] = 1'b1; st_wdata[0] = 32'h8; step("R8");
    st_we[0] = 1'b1; st_wdata[0] = 32'h8; step("R7");

    // pop of empty queue while the peer pushes into it
    tx_valid[1] = 1'b1; tx_data[1] = 32'h0000_0077; rx_pop[0] = 1'b1; step("R6");
    rx_pop[0] = 1'b1; step("R4");

    // core 0 fills its queue, overflow meets a clear in one cycle
    for (int i = 0; i < 8; i++) begin
      tx_valid[0] = 1'b1; tx_data[0] = 32'h1234_0000 ^ (i << 4); step("R1");
    end
    tx_valid[0] = 1'b1; tx_data[0] = 32'h5555_5555;
    st_we[0] = 1'b1; st_wdata[0] = 32'h4; step("R8");
    tx_valid[0] = 1'b1; tx_data[0] = 32'h6666_6666; step("R5");

    // reset with data and flags present
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    q0.delete(); q1.delete(); mov = '0; mud = '0;
    check_all("R11");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule